// File: doc/BRIEF.md
# Line-Rate Jitter Attenuator FIFO

This block is a bit-serial elastic store for one T1/E1 line path. Single data bits arrive with a write strobe. The strobe may be jittery, gapped or bursty. The bits are put into a circular buffer and later read out on an evenly paced strobe. That pace comes from dividing a fast reference, which runs at sixteen times the line rate. The reference is the only clock, and both strobes are enables in its domain. The read period is normally 16 reference cycles. When the buffer fill strays too far from the centre, the pacer takes a single short period of 15 or a single long period of 17, which pulls the fill back. Each such correction sets a sticky limit-trip flag.

The store can sit in the receive stream or in the transmit stream, or it can be switched out. A path that does not hold the store carries its bit and strobe straight from input to output through combinational logic only. Depth is 32 bits, which gives low delay, or 128 bits, which gives wide wander tolerance. Two further sticky flags report reads from an empty store and writes into a full one.

The pacer is a three-state machine:
- FLUSH: the store is cleared and nothing is read.
- PRIME: waits for the store to fill to half depth.
- RUN: produces read strobes.

Its transitions are:
- T_PURGE: from any state into FLUSH, on a flush request.
- T_ARM: FLUSH to PRIME, in the first cycle without a flush request.
- T_START: PRIME to RUN, when the fill is at least half depth.
- T_KEEP: RUN stays in RUN.

A flush request is raised by reset, by the attenuator being disabled, or by a change of depth or path select.

Top module: `jitter_smoother`

## Requirements
- R1: With `atten_en`=0, `rx_out`/`rx_out_stb` equal `rx_bit`/`rx_stb` and `tx_out`/`tx_out_stb` equal `tx_bit`/`tx_stb`, combinationally, in the same cycle.
- R2: With `atten_en`=1, `path_tx`=0 puts the store on the receive stream, and `path_tx`=1 puts it on the transmit stream. The other stream passes through combinationally, as in R1.
- R3: Bits accepted into the store leave it in the order they were written, one per output strobe.
- R4: After a flush, no output strobe appears until the fill reaches half depth: 16 when `deep_mode`=0, 64 when `deep_mode`=1. The first strobe appears 17 cycles after the clock edge that accepts the bit reaching half depth.
- R5: While the fill stays within the centre ± margin, output strobes are exactly 16 cycles apart, even when the write strobe is gapped or bursty.
- R6: If the fill seen in the cycle of an output strobe is above half depth by more than the margin (14 in 32-bit mode, 60 in 128-bit mode), the next period is 15 cycles.
- R7: If the fill seen in the cycle of an output strobe is below half depth by more than the margin, the next period is 17 cycles.
- R8: `trip_flag` is set in the cycle after every 15- or 17-cycle period is chosen, and stays set until `flag_clr`=1. `flag_clr` clears all three flags. When a set and a clear fall in the same cycle, the set wins.
- R9: A strobe that reads from an empty store still appears, repeats the previous output bit, and sets the sticky `under_flag`.
- R10: A write while the store holds its full depth is dropped, and sets the sticky `over_flag`. The fill never exceeds the selected depth.
- R11: A change of `deep_mode` or `path_tx`, or `atten_en`=0, empties the store. This drives the stored output bit to 0, stops the output strobes, and requires a new half-depth priming.
- R12: During and after reset, all three flags are 0, the store is empty, and the stored output bit and strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 16 times the line rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| atten_en | input | 1 | 1 inserts the store into a path, 0 bypasses both paths |
| path_tx | input | 1 | 1 puts the store on the transmit stream, 0 on the receive stream |
| deep_mode | input | 1 | 1 selects 128-bit depth, 0 selects 32-bit depth |
| flag_clr | input | 1 | Clears the three sticky flags |
| rx_bit | input | 1 | Receive stream data bit |
| rx_stb | input | 1 | Receive stream write strobe |
| tx_bit | input | 1 | Transmit stream data bit |
| tx_stb | input | 1 | Transmit stream write strobe |
| rx_out | output | 1 | Receive stream output bit |
| rx_out_stb | output | 1 | Receive stream output strobe |
| tx_out | output | 1 | Transmit stream output bit |
| tx_out_stb | output | 1 | Transmit stream output strobe |
| trip_flag | output | 1 | Sticky: an off-nominal period was used |
| under_flag | output | 1 | Sticky: a read found the store empty |
| over_flag | output | 1 | Sticky: a write found the store full |

## Verification
Two events can fall on the same clock edge: a corrective period choice that sets `trip_flag`, and a software clear of that flag. The bench first overfills the 32-bit store with a burst of writes, so that the next read strobes must choose 15-cycle periods. It then holds `flag_clr` high across those strobes. The expected result is that `trip_flag` reads 1 only in the sample that carries the corrective strobe, and reads 0 again one sample later.

// File: rtl/js_pkg.sv
package js_pkg;

    // pacer states
    typedef enum logic [1:0] {
        ST_FLUSH = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2
    } js_state_t;

    // index of each sticky flag
    localparam int FLG_TRIP  = 0;
    localparam int FLG_UNDER = 1;
    localparam int FLG_OVER  = 2;
    localparam int FLG_COUNT = 3;

endpackage

// File: rtl/js_fifo.sv
module js_fifo #(
    parameter int MAX_DEPTH = 128,
    parameter int CW        = $clog2(MAX_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] depth,
    input  logic          wr_en,
    input  logic          wr_bit,
    input  logic          rd_en,
    output logic          rd_bit,
    output logic [CW-1:0] fill,
    output logic          ovf_evt,
    output logic          unf_evt
);

    localparam int AW = $clog2(MAX_DEPTH);

    logic          mem [MAX_DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          is_full;
    logic          is_empty;
    logic          do_wr;
    logic          do_rd;

    always_comb begin
        is_full  = (fill == depth);
        is_empty = (fill == '0);
        do_wr    = wr_en && !is_full  && !flush;
        do_rd    = rd_en && !is_empty && !flush;
        ovf_evt  = wr_en && is_full   && !flush;
        unf_evt  = rd_en && is_empty  && !flush;
    end

    // pointers wrap over the whole array; depth only limits the fill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            rd_bit <= 1'b0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            rd_bit <= 1'b0;
        end else begin
            if (do_wr) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_rd) begin
                rd_ptr <= rd_ptr + 1'b1;
                rd_bit <= mem[rd_ptr];
            end
            unique case ({do_wr, do_rd})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_bit;
        end
    end

endmodule

// File: rtl/js_pacer.sv
module js_pacer
    import js_pkg::*;
#(
    parameter int NOM_DIV = 16,
    parameter int CW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] fill,
    input  logic [CW-1:0] half,
    input  logic [CW-1:0] margin,
    output logic          rd_req,
    output logic          trip_evt,
    output js_state_t     state
);

    localparam int PW = $clog2(NOM_DIV + 2);
    localparam logic [PW-1:0] P_NOM  = PW'(NOM_DIV);
    localparam logic [PW-1:0] P_FAST = PW'(NOM_DIV - 1);
    localparam logic [PW-1:0] P_SLOW = PW'(NOM_DIV + 1);

    js_state_t     state_q;
    js_state_t     state_d;
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] len_q;
    logic [PW-1:0] choice;
    logic [CW:0]   hi_lim;
    logic [CW:0]   lo_sum;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLUSH;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_PURGE, T_ARM, T_START, T_KEEP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLUSH: state_d = flush ? ST_FLUSH : ST_PRIME;
            ST_PRIME: begin
                if (flush) begin
                    state_d = ST_FLUSH;
                end else if (fill >= half) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN:   state_d = flush ? ST_FLUSH : ST_RUN;
            default:  state_d = ST_FLUSH;
        endcase
    end

    // outputs: read request and next-period choice
    always_comb begin
        hi_lim   = {1'b0, half} + {1'b0, margin};
        lo_sum   = {1'b0, fill} + {1'b0, margin};
        rd_req   = 1'b0;
        choice   = P_NOM;
        unique case (state_q)
            ST_RUN: begin
                rd_req = !flush && (cnt_q == len_q - 1'b1);
                if ({1'b0, fill} > hi_lim) begin
                    choice = P_FAST;
                end else if (lo_sum < {1'b0, half}) begin
                    choice = P_SLOW;
                end
            end
            default: rd_req = 1'b0;
        endcase
        trip_evt = rd_req && (choice != P_NOM);
        state    = state_q;
    end

    // period divider
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= P_NOM;
        end else if (state_q != ST_RUN) begin
            cnt_q <= '0;
            len_q <= P_NOM;
        end else if (rd_req) begin
            cnt_q <= '0;
            len_q <= choice;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/js_sticky.sv
module js_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flag
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else begin
                bit_q <= set[g] | (bit_q & ~clr);
            end
        end
        assign flag[g] = bit_q;
    end

endmodule

// File: rtl/jitter_smoother.sv
module jitter_smoother
    import js_pkg::*;
#(
    parameter int BIG_DEPTH    = 128,
    parameter int SMALL_DEPTH  = 32,
    parameter int BIG_MARGIN   = 60,
    parameter int SMALL_MARGIN = 14,
    parameter int NOM_DIV      = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic atten_en,
    input  logic path_tx,
    input  logic deep_mode,
    input  logic flag_clr,
    input  logic rx_bit,
    input  logic rx_stb,
    input  logic tx_bit,
    input  logic tx_stb,
    output logic rx_out,
    output logic rx_out_stb,
    output logic tx_out,
    output logic tx_out_stb,
    output logic trip_flag,
    output logic under_flag,
    output logic over_flag
);

    localparam int CW = $clog2(BIG_DEPTH + 1);

    logic            mode_q;
    logic            path_q;
    logic            flush;
    logic [CW-1:0]   depth;
    logic [CW-1:0]   half;
    logic [CW-1:0]   margin;
    logic            sel_bit;
    logic            sel_stb;
    logic            rd_en;
    logic            att_bit;
    logic            att_stb;
    logic [CW-1:0]   fill;
    logic            ovf_evt;
    logic            unf_evt;
    logic            trip_evt;
    js_state_t       pacer_state;
    logic [FLG_COUNT-1:0] flg_set;
    logic [FLG_COUNT-1:0] flg;

    // track the selects to spot a change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            path_q <= 1'b0;
        end else begin
            mode_q <= deep_mode;
            path_q <= path_tx;
        end
    end

    always_comb begin
        flush   = !atten_en || (deep_mode != mode_q) || (path_tx != path_q);
        depth   = deep_mode ? CW'(BIG_DEPTH)      : CW'(SMALL_DEPTH);
        half    = deep_mode ? CW'(BIG_DEPTH / 2)  : CW'(SMALL_DEPTH / 2);
        margin  = deep_mode ? CW'(BIG_MARGIN)     : CW'(SMALL_MARGIN);
        sel_bit = path_tx ? tx_bit : rx_bit;
        sel_stb = path_tx ? tx_stb : rx_stb;
    end

    js_fifo #(
        .MAX_DEPTH (BIG_DEPTH),
        .CW        (CW)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .depth   (depth),
        .wr_en   (sel_stb),
        .wr_bit  (sel_bit),
        .rd_en   (rd_en),
        .rd_bit  (att_bit),
        .fill    (fill),
        .ovf_evt (ovf_evt),
        .unf_evt (unf_evt)
    );

    js_pacer #(
        .NOM_DIV (NOM_DIV),
        .CW      (CW)
    ) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .fill     (fill),
        .half     (half),
        .margin   (margin),
        .rd_req   (rd_en),
        .trip_evt (trip_evt),
        .state    (pacer_state)
    );

    // output strobe lines up with the registered read bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            att_stb <= 1'b0;
        end else begin
            att_stb <= rd_en;
        end
    end

    always_comb begin
        flg_set            = '0;
        flg_set[FLG_TRIP]  = trip_evt;
        flg_set[FLG_UNDER] = unf_evt;
        flg_set[FLG_OVER]  = ovf_evt;
    end

    js_sticky #(
        .N (FLG_COUNT)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flag_clr),
        .set   (flg_set),
        .flag  (flg)
    );

    always_comb begin
        trip_flag  = flg[FLG_TRIP];
        under_flag = flg[FLG_UNDER];
        over_flag  = flg[FLG_OVER];
        rx_out     = rx_bit;
        rx_out_stb = rx_stb;
        tx_out     = tx_bit;
        tx_out_stb = tx_stb;
        if (atten_en) begin
            if (path_tx) begin
                tx_out     = att_bit;
                tx_out_stb = att_stb;
            end else begin
                rx_out     = att_bit;
                rx_out_stb = att_stb;
            end
        end
    end

endmodule

// File: rtl/js_checks.sv
module js_checks
    import js_pkg::*;
#(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          rd_en,
    input logic          trip_evt,
    input logic          trip_flag,
    input logic          unf_evt,
    input logic          under_flag,
    input logic          att_bit,
    input logic          att_stb,
    input logic [CW-1:0] fill,
    input logic [CW-1:0] depth,
    input logic [CW-1:0] half,
    input js_state_t     state
);

    logic [7:0] gap;
    logic       seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (flush) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (rd_en) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != 8'hFF) begin
            gap <= gap + 1'b1;
        end
    end

    assert_period_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && seen) |-> (gap >= 8'd14 && gap <= 8'd16));

    assert_start_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) == ST_PRIME) |-> ($past(fill) >= $past(half)));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= depth);

    assert_trip_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trip_evt |=> trip_flag);

    assert_under_repeat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unf_evt |=> (under_flag && att_stb && $stable(att_bit)));

    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill == '0 && !att_stb && !att_bit));

endmodule

bind jitter_smoother js_checks #(.CW(CW)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .rd_en      (rd_en),
    .trip_evt   (trip_evt),
    .trip_flag  (trip_flag),
    .unf_evt    (unf_evt),
    .under_flag (under_flag),
    .att_bit    (att_bit),
    .att_stb    (att_stb),
    .fill       (fill),
    .depth      (depth),
    .half       (half),
    .state      (pacer_state)
);

// File: tb/test_jitter_smoother.sv
module test_jitter_smoother;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, pth = 1'b0, deep = 1'b0, clr = 1'b0;
    logic rxb = 1'b0, rxs = 1'b0, txb = 1'b0, txs = 1'b0;
    logic rx_out, rx_out_stb, tx_out, tx_out_stb;
    logic trip_flag, under_flag, over_flag;

    int n_chk = 0, n_err = 0;
    int since = 0, last_gap = 0, nstb = 0;
    bit data_on = 0, saw15 = 0, saw17 = 0;
    bit q[$];

    always #2 clk = ~clk;

    jitter_smoother i_jitter_smoother (
        .clk(clk), .rst_n(rst_n), .atten_en(en), .path_tx(pth),
        .deep_mode(deep), .flag_clr(clr),
        .rx_bit(rxb), .rx_stb(rxs), .tx_bit(txb), .tx_stb(txs),
        .rx_out(rx_out), .rx_out_stb(rx_out_stb),
        .tx_out(tx_out), .tx_out_stb(tx_out_stb),
        .trip_flag(trip_flag), .under_flag(under_flag), .over_flag(over_flag)
    );

    // {en,path,rxb,rxs,txb,txs, exp rx_out,rx_out_stb,tx_out,tx_out_stb}
    localparam logic [9:0] VEC [8] = '{
        10'b0_0_1_1_0_0_1_1_0_0,
        10'b0_1_0_0_1_1_0_0_1_1,
        10'b0_0_1_0_1_0_1_0_1_0,
        10'b1_0_1_1_1_0_0_0_1_0,
        10'b1_0_0_0_1_1_0_0_1_1,
        10'b1_1_1_1_0_1_1_1_0_0,
        10'b1_1_0_1_1_1_0_1_0_0,
        10'b0_1_1_1_1_1_1_1_1_1
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic att_s();
        return pth ? tx_out_stb : rx_out_stb;
    endfunction

    function automatic logic att_b();
        return pth ? tx_out : rx_out;
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
        since++;
        if (att_s()) begin
            last_gap = since;
            since = 0;
            nstb++;
            if (last_gap == 15) saw15 = 1;
            if (last_gap == 17) saw17 = 1;
            if (data_on) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R3 strobe with no bit written", 1, 0);
                end else begin
                    bit e;
                    e = q.pop_front();
                    chk(att_b() == e, "R3 output order", int'(att_b()), int'(e));
                end
            end
        end
    endtask

    task automatic put(input bit b);
        if (pth) begin txb = b; txs = 1'b1; end
        else begin rxb = b; rxs = 1'b1; end
        q.push_back(b);
        cyc();
        rxs = 1'b0;
        txs = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wait_stb(output int j);
        j = 0;
        do begin
            cyc();
            j++;
        end while (!att_s() && j < 60);
    endtask

    task summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        int j, n0, nset;
        bit prev_t, prev_b, useen;

        // reset state (R12)
        repeat (3) @(posedge clk);
        #1;
        chk(!trip_flag && !under_flag && !over_flag, "R12 flags in reset",
            int'({trip_flag, under_flag, over_flag}), 0);
        rst_n = 1'b1;
        cyc();
        chk(rx_out == 0 && rx_out_stb == 0 && tx_out_stb == 0, "R12 outputs after reset",
            int'({rx_out, rx_out_stb, tx_out_stb}), 0);

        // vector table: bypass and path select (R1, R2)
        for (int v = 0; v < 8; v++) begin
            {en, pth, rxb, rxs, txb, txs} = VEC[v][9:4];
            #1;
            chk({rx_out, rx_out_stb, tx_out, tx_out_stb} == VEC[v][3:0],
                $sformatf("R1/R2 vector %0d", v),
                int'({rx_out, rx_out_stb, tx_out, tx_out_stb}), int'(VEC[v][3:0]));
            cyc();
        end
        rxs = 0; txs = 0;

        // shallow priming, order and nominal pacing (R4, R3, R5)
        en = 1; pth = 0; deep = 0;
        idle(3);
        q.delete(); data_on = 1; n0 = nstb;
        for (int i = 0; i < 15; i++) put(bit'((i * 5 + 1) % 3 == 0));
        chk(nstb == n0, "R4 no strobe before half fill", nstb - n0, 0);
        put(1'b1);
        wait_stb(j);
        chk(j == 17, "R4 first strobe delay 32-bit", j, 17);
        for (int s = 0; s < 6; s++) begin
            put(bit'(s[0] ^ s[1]));
            wait_stb(j);
            chk(last_gap == 16, "R5 nominal gap", last_gap, 16);
        end
        chk(trip_flag == 0, "R8 no trip when centred", int'(trip_flag), 0);

        // overfill burst: overflow, fast periods, set-wins clear (R10, R6, R8)
        data_on = 0; saw15 = 0; saw17 = 0;
        for (int i = 0; i < 20; i++) put(bit'(i[0]));
        chk(over_flag == 1, "R10 write at full flagged", int'(over_flag), 1);
        clr = 1; nset = 0; prev_t = 0;
        for (int i = 0; i < 60; i++) begin
            cyc();
            if (trip_flag) begin
                nset++;
                chk(att_s() == 1, "R8 set wins only at strobe", int'(att_s()), 1);
            end
            if (prev_t) chk(trip_flag == 0, "R8 clear after set", int'(trip_flag), 0);
            prev_t = trip_flag;
        end
        chk(nset >= 1, "R8 trip seen under clear", nset, 1);
        chk(saw15 == 1, "R6 fast period used", int'(saw15), 1);
        chk(over_flag == 0, "R8 clear drops over flag", int'(over_flag), 0);
        clr = 0;
        idle(40);
        chk(trip_flag == 0 && under_flag == 0, "R8 stays clear when centred",
            int'({trip_flag, under_flag}), 0);

        // drain: slow periods and underflow repeat (R7, R9)
        useen = 0;
        for (int i = 0; i < 900 && !useen; i++) begin
            prev_b = att_b();
            cyc();
            if (under_flag) begin
                useen = 1;
                chk(att_s() == 1, "R9 strobe on empty read", int'(att_s()), 1);
                chk(att_b() == prev_b, "R9 repeat last bit", int'(att_b()), int'(prev_b));
            end
        end
        chk(useen == 1, "R9 underflow flagged", int'(useen), 1);
        chk(saw17 == 1, "R7 slow period used", int'(saw17), 1);
        chk(trip_flag == 1, "R7 slow period trips", int'(trip_flag), 1);

        // depth change flush and deep priming (R11, R4, R5)
        deep = 1;
        idle(3);
        chk(att_b() == 0 && att_s() == 0, "R11 flush clears output",
            int'({att_b(), att_s()}), 0);
        clr = 1; cyc(); clr = 0;
        q.delete(); data_on = 1; n0 = nstb;
        for (int i = 0; i < 63; i++) put(bit'((i % 7) < 3));
        idle(20);
        chk(nstb == n0, "R11 refill needed after depth change", nstb - n0, 0);
        put(1'b0);
        wait_stb(j);
        chk(j == 17, "R4 first strobe delay 128-bit", j, 17);
        for (int s = 0; s < 4; s++) begin
            put(bit'(s[0]));
            wait_stb(j);
            chk(last_gap == 16, "R5 deep nominal gap", last_gap, 16);
        end

        // transmit path with bursty writes (R2, R5, R3)
        pth = 1;
        idle(3);
        q.delete(); n0 = 0;
        for (int t = 0; t < 3000; t++) begin
            txs = ((t % 128) < 8);
            txb = bit'((t * 13 + t / 5) % 3 == 1);
            if (txs) q.push_back(txb);
            rxb = bit'(t[0] ^ t[3]);
            rxs = t[1];
            #1;
            if (t % 16 == 0)
                chk(rx_out == rxb && rx_out_stb == rxs, "R2 receive pass-through",
                    int'({rx_out, rx_out_stb}), int'({rxb, rxs}));
            cyc();
            if (att_s()) begin
                if (n0 > 0) chk(last_gap == 16, "R5 gapped writes even gap", last_gap, 16);
                n0++;
            end
        end
        txs = 0; rxs = 0;
        chk(n0 >= 10, "R5 strobes with gapped writes", n0, 10);
        chk(under_flag == 0 && over_flag == 0, "R10 no error when centred",
            int'({under_flag, over_flag}), 0);

        // reset during operation (R12)
        data_on = 0;
        rst_n = 0;
        idle(2);
        chk(tx_out == 0 && tx_out_stb == 0 && !trip_flag && !under_flag && !over_flag,
            "R12 mid-run reset", int'({tx_out, tx_out_stb, trip_flag, under_flag, over_flag}), 0);
        rst_n = 1;
        idle(2);

        summary();
        $finish;
    end

endmodule